// File: doc/BRIEF.md
# CAN Transmit Mailbox Scheduler

This block sits between a set of transmit mailboxes and a CAN frame transmitter. Software-side logic loads a mailbox through a valid/ready request port with an identifier. The mailbox then becomes pending. Whenever the transmitter is idle and at least one mailbox is pending, the block picks one, presents its index and identifier, and issues a single-cycle start pulse. It holds that choice until the transmitter reports how the attempt ended.

Two run-time configuration bits set the policy. The first selects how the next mailbox is chosen:
- by identifier, where the numerically lowest identifier wins;
- by the order in which requests were accepted.

The second selects what happens after a failed attempt:
- the mailbox can stay pending and be retried, keeping its place in request order;
- or it can be released after a single attempt, whatever the outcome.

Every release raises a one-cycle done pulse for that mailbox. It also updates a sticky success flag for that mailbox.

Top module: `can_tx_sched`

## Requirements
- R1: After reset no mailbox is pending, `tx_start`, `tx_busy` and all `mb_done`/`mb_ok` bits are 0, and `req_ready` is 1.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1, and the addressed mailbox reads pending from the next cycle. `req_ready` is 0 while the addressed mailbox is pending. The requester must then hold its request, which has no effect on the stored identifier.
- R3: When the block is idle and a mailbox is pending, `tx_start` is high for exactly one cycle, with `tx_busy` rising at the same time. `tx_sel` and `tx_id` stay constant until `tx_done`, and no further start occurs while busy.
- R4: With `cfg_fifo_order` = 0, the pending mailbox with the numerically lowest identifier is started. Among equal identifiers, the lowest mailbox index wins.
- R5: With `cfg_fifo_order` = 1, the pending mailbox whose request was accepted earliest is started, regardless of identifiers.
- R6: With `cfg_one_shot` = 0, a completion with `tx_result` other than 2'b00 leaves the mailbox pending with no done pulse. In request-order mode, the retried mailbox keeps its place ahead of later requests.
- R7: A completion with `tx_result` = 2'b00 releases the selected mailbox. Its pending bit clears and its `mb_done` bit pulses in the same cycle, one cycle after `tx_done`, and its `mb_ok` bit becomes 1.
- R8: With `cfg_one_shot` = 1, any completion releases the mailbox. Result codes 2'b01 (error) and 2'b10 (arbitration lost) give `mb_ok` = 0.
- R9: A `tx_done` pulse while `tx_busy` is 0 has no effect on mailboxes or outputs.
- R10: A released mailbox may be requested again. In request-order mode, that new request ranks behind every mailbox already pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fifo_order | input | 1 | 0: identifier priority, 1: request order |
| cfg_one_shot | input | 1 | 1: release after a single attempt |
| req_valid | input | 1 | Mailbox load request valid |
| req_ready | output | 1 | Addressed mailbox free to accept |
| req_mb | input | 2 | Mailbox index of the request |
| req_id | input | 11 | Frame identifier for the mailbox |
| tx_start | output | 1 | One-cycle start pulse to transmitter |
| tx_busy | output | 1 | Attempt in flight |
| tx_sel | output | 2 | Selected mailbox index |
| tx_id | output | 11 | Identifier of selected mailbox |
| tx_done | input | 1 | Attempt finished (one cycle) |
| tx_result | input | 2 | 00 success, 01 error, 10 arbitration lost |
| mb_pending | output | 3 | Per-mailbox pending flags |
| mb_done | output | 3 | Per-mailbox release pulse |
| mb_ok | output | 3 | Per-mailbox last release status, 1 = sent |

## Verification
The assertions assume three things about the inputs:
- `req_mb` always addresses an existing mailbox;
- `tx_done` is a single-cycle pulse;
- a `tx_result` is meaningful only alongside `tx_done`.

The stimulus keeps to these assumptions. Requests use indices 0 to 2 only. Completions are driven for exactly one cycle, and only after a start has been observed, except in the one directed case that checks the idle-completion rule. That case is still a single-cycle pulse. Configuration bits are changed only while no mailbox is pending.

// File: rtl/can_sched_pkg.sv
package can_sched_pkg;

  typedef enum logic [1:0] {
    RES_OK  = 2'b00,
    RES_ERR = 2'b01,
    RES_ARB = 2'b10,
    RES_RSV = 2'b11
  } tx_res_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } sched_state_e;

endpackage

// File: rtl/can_mb_bank.sv
module can_mb_bank #(
  parameter int NUM_MB = 3,
  parameter int ID_W   = 11,
  parameter int SEL_W  = 2,
  parameter int RANK_W = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          acc,
  input  logic [SEL_W-1:0]              acc_mb,
  input  logic [ID_W-1:0]               acc_id,
  input  logic                          rel,
  input  logic [SEL_W-1:0]              rel_mb,
  output logic [NUM_MB-1:0]             pending,
  output logic [NUM_MB-1:0][ID_W-1:0]   ids,
  output logic [NUM_MB-1:0][RANK_W-1:0] ranks
);
  localparam int CNT_W = $clog2(NUM_MB + 1);

  logic [CNT_W-1:0]  pend_cnt;
  logic [RANK_W-1:0] rel_rank;
  logic [RANK_W-1:0] new_rank;

  // Arrival rank: 0 is the oldest pending request; ranks are dense.
  always_comb begin
    pend_cnt = '0;
    for (int i = 0; i < NUM_MB; i++) begin
      pend_cnt = pend_cnt + CNT_W'(pending[i]);
    end
    rel_rank = ranks[rel_mb];
    new_rank = RANK_W'(pend_cnt - CNT_W'(rel));
  end

  for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
    localparam logic [SEL_W-1:0] IDX = SEL_W'(g);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pending[g] <= 1'b0;
        ids[g]     <= '0;
        ranks[g]   <= '0;
      end else if (rel && rel_mb == IDX) begin
        pending[g] <= 1'b0;
        ranks[g]   <= '0;
      end else if (acc && acc_mb == IDX) begin
        pending[g] <= 1'b1;
        ids[g]     <= acc_id;
        ranks[g]   <= new_rank;
      end else if (rel && pending[g] && ranks[g] > rel_rank) begin
        ranks[g]   <= ranks[g] - 1'b1;
      end
    end
  end

endmodule

// File: rtl/can_mb_arbiter.sv
module can_mb_arbiter #(
  parameter int NUM_MB = 3,
  parameter int ID_W   = 11,
  parameter int SEL_W  = 2,
  parameter int RANK_W = 2
) (
  input  logic                          fifo_order,
  input  logic [NUM_MB-1:0]             pending,
  input  logic [NUM_MB-1:0][ID_W-1:0]   ids,
  input  logic [NUM_MB-1:0][RANK_W-1:0] ranks,
  output logic                          found,
  output logic [SEL_W-1:0]              win
);
  logic [SEL_W-1:0]  id_win;
  logic [ID_W-1:0]   id_best;
  logic              id_any;
  logic [SEL_W-1:0]  age_win;
  logic [RANK_W-1:0] age_best;
  logic              age_any;

  // Lowest identifier; strict compare keeps the lower index on ties.
  always_comb begin
    id_win  = '0;
    id_best = '0;
    id_any  = 1'b0;
    for (int i = 0; i < NUM_MB; i++) begin
      if (pending[i] && (!id_any || ids[i] < id_best)) begin
        id_any  = 1'b1;
        id_best = ids[i];
        id_win  = SEL_W'(i);
      end
    end
  end

  // Lowest arrival rank among pending mailboxes.
  always_comb begin
    age_win  = '0;
    age_best = '0;
    age_any  = 1'b0;
    for (int i = 0; i < NUM_MB; i++) begin
      if (pending[i] && (!age_any || ranks[i] < age_best)) begin
        age_any  = 1'b1;
        age_best = ranks[i];
        age_win  = SEL_W'(i);
      end
    end
  end

  assign found = |pending;
  assign win   = fifo_order ? age_win : id_win;

endmodule

// File: rtl/can_tx_sched.sv
module can_tx_sched #(
  parameter int NUM_MB = 3,
  parameter int ID_W   = 11,
  parameter int SEL_W  = $clog2(NUM_MB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_fifo_order,
  input  logic              cfg_one_shot,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SEL_W-1:0]  req_mb,
  input  logic [ID_W-1:0]   req_id,
  output logic              tx_start,
  output logic              tx_busy,
  output logic [SEL_W-1:0]  tx_sel,
  output logic [ID_W-1:0]   tx_id,
  input  logic              tx_done,
  input  logic [1:0]        tx_result,
  output logic [NUM_MB-1:0] mb_pending,
  output logic [NUM_MB-1:0] mb_done,
  output logic [NUM_MB-1:0] mb_ok
);
  import can_sched_pkg::*;

  localparam int RANK_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1;

  sched_state_e                 state_q;
  logic                         start_q;
  logic [SEL_W-1:0]             sel_q;
  logic [NUM_MB-1:0]            done_q;
  logic [NUM_MB-1:0]            ok_q;
  logic [NUM_MB-1:0]            pend;
  logic [NUM_MB-1:0][ID_W-1:0]  ids;
  logic [NUM_MB-1:0][RANK_W-1:0] ranks;
  logic                         acc;
  logic                         finish;
  logic                         success;
  logic                         rel;
  logic                         found;
  logic [SEL_W-1:0]             win;

  assign req_ready = !pend[req_mb];
  assign acc       = req_valid && req_ready;
  assign finish    = (state_q == ST_BUSY) && tx_done;
  assign success   = (tx_result == RES_OK);
  assign rel       = finish && (success || cfg_one_shot);

  can_mb_bank #(
    .NUM_MB(NUM_MB), .ID_W(ID_W), .SEL_W(SEL_W), .RANK_W(RANK_W)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc     (acc),
    .acc_mb  (req_mb),
    .acc_id  (req_id),
    .rel     (rel),
    .rel_mb  (sel_q),
    .pending (pend),
    .ids     (ids),
    .ranks   (ranks)
  );

  can_mb_arbiter #(
    .NUM_MB(NUM_MB), .ID_W(ID_W), .SEL_W(SEL_W), .RANK_W(RANK_W)
  ) u_arb (
    .fifo_order (cfg_fifo_order),
    .pending    (pend),
    .ids        (ids),
    .ranks      (ranks),
    .found      (found),
    .win        (win)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      start_q <= 1'b0;
      sel_q   <= '0;
    end else begin
      start_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (found) begin
          state_q <= ST_BUSY;
          start_q <= 1'b1;
          sel_q   <= win;
        end
        ST_BUSY: if (tx_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_MB; g++) begin : g_stat
    localparam logic [SEL_W-1:0] IDX = SEL_W'(g);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        done_q[g] <= 1'b0;
        ok_q[g]   <= 1'b0;
      end else begin
        done_q[g] <= rel && sel_q == IDX;
        if (rel && sel_q == IDX) ok_q[g] <= success;
      end
    end
  end

  assign tx_start   = start_q;
  assign tx_busy    = (state_q == ST_BUSY);
  assign tx_sel     = sel_q;
  assign tx_id      = ids[sel_q];
  assign mb_pending = pend;
  assign mb_done    = done_q;
  assign mb_ok      = ok_q;

endmodule

// File: rtl/can_tx_sched_chk.sv
module can_tx_sched_chk #(
  parameter int NUM_MB = 3,
  parameter int ID_W   = 11,
  parameter int SEL_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_one_shot,
  input logic              req_valid,
  input logic              req_ready,
  input logic [SEL_W-1:0]  req_mb,
  input logic              tx_start,
  input logic              tx_busy,
  input logic [SEL_W-1:0]  tx_sel,
  input logic [ID_W-1:0]   tx_id,
  input logic              tx_done,
  input logic [1:0]        tx_result,
  input logic [NUM_MB-1:0] mb_pending,
  input logic [NUM_MB-1:0] mb_done
);

  a_r2_accept_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> mb_pending[$past(req_mb)]);

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |=> !tx_start);

  a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> (tx_busy && mb_pending[tx_sel]));

  a_r3_choice_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !tx_done) |=> ($stable(tx_sel) && $stable(tx_id)));

  a_r7_release_on_success: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && tx_done && tx_result == 2'b00)
      |=> (mb_done[$past(tx_sel)] && !mb_pending[$past(tx_sel)]));

  a_r6_retry_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && tx_done && tx_result != 2'b00 && !cfg_one_shot)
      |=> (mb_pending[$past(tx_sel)] && mb_done == '0));

  a_r8_one_shot_release: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && tx_done && cfg_one_shot) |=> mb_done[$past(tx_sel)]);

  a_r9_idle_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && tx_done) |=> (mb_done == '0));

  a_r7_one_release: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mb_done));

endmodule

bind can_tx_sched can_tx_sched_chk #(
  .NUM_MB(NUM_MB), .ID_W(ID_W), .SEL_W(SEL_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_one_shot (cfg_one_shot),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_mb       (req_mb),
  .tx_start     (tx_start),
  .tx_busy      (tx_busy),
  .tx_sel       (tx_sel),
  .tx_id        (tx_id),
  .tx_done      (tx_done),
  .tx_result    (tx_result),
  .mb_pending   (mb_pending),
  .mb_done      (mb_done)
);

// File: tb/can_tx_sched_tb.sv
module can_tx_sched_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_fifo_order = 1'b0;
  logic        cfg_one_shot = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_mb = '0;
  logic [10:0] req_id = '0;
  logic        tx_start;
  logic        tx_busy;
  logic [1:0]  tx_sel;
  logic [10:0] tx_id;
  logic        tx_done = 1'b0;
  logic [1:0]  tx_result = 2'b00;
  logic [2:0]  mb_pending;
  logic [2:0]  mb_done;
  logic [2:0]  mb_ok;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  can_tx_sched u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_fifo_order(cfg_fifo_order),
    .cfg_one_shot(cfg_one_shot), .req_valid(req_valid), .req_ready(req_ready),
    .req_mb(req_mb), .req_id(req_id), .tx_start(tx_start), .tx_busy(tx_busy),
    .tx_sel(tx_sel), .tx_id(tx_id), .tx_done(tx_done), .tx_result(tx_result),
    .mb_pending(mb_pending), .mb_done(mb_done), .mb_ok(mb_ok)
  );

  task automatic check(input bit cond, input string tag, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic request(input logic [1:0] mb, input logic [10:0] id);
    @(negedge clk);
    req_valid = 1'b1; req_mb = mb; req_id = id;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_start(input logic [1:0] exp_sel, input string tag);
    bit seen = 0;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      if (tx_start) seen = 1;
    end
    check(seen && tx_sel == exp_sel, tag, seen ? int'(tx_sel) : -1, int'(exp_sel));
  endtask

  task automatic complete(input logic [1:0] res);
    @(negedge clk);
    tx_done = 1'b1; tx_result = res;
    @(negedge clk);
    tx_done = 1'b0; tx_result = 2'b00;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(mb_pending == 3'b000, "R1 pending", mb_pending, 0);
    check(!tx_start && !tx_busy, "R1 start/busy", {tx_start, tx_busy}, 0);
    check(mb_done == 0 && mb_ok == 0, "R1 done/ok", {mb_done, mb_ok}, 0);
    check(req_ready, "R1 ready", req_ready, 1);
  endtask

  task automatic t_id_priority();
    cfg_fifo_order = 1'b0; cfg_one_shot = 1'b0;
    request(2'd0, 11'h100);
    check(mb_pending[0], "R2 pending after accept", mb_pending, 1);
    wait_start(2'd0, "R3 first start");
    request(2'd1, 11'h050);
    request(2'd2, 11'h050);
    check(tx_sel == 2'd0 && tx_id == 11'h100, "R3 held while busy", tx_id, 11'h100);
    complete(2'b00);
    check(mb_done == 3'b001 && !mb_pending[0], "R7 release",
          {mb_done, mb_pending}, 6'b001110);
    check(mb_ok[0], "R7 ok", mb_ok, 1);
    wait_start(2'd1, "R4 tie to lower index");
    check(tx_id == 11'h050, "R4 id", tx_id, 11'h050);
    complete(2'b00);
    wait_start(2'd2, "R4 remaining");
    complete(2'b00);
    @(negedge clk);
    check(mb_pending == 0 && !tx_busy, "R7 all drained", mb_pending, 0);
  endtask

  task automatic t_id_lowest();
    cfg_fifo_order = 1'b0;
    request(2'd0, 11'h7FF);
    wait_start(2'd0, "R4 blocker");
    request(2'd1, 11'h400);
    request(2'd2, 11'h020);
    complete(2'b00);
    wait_start(2'd2, "R4 lowest id wins");
    complete(2'b00);
    wait_start(2'd1, "R4 next lowest");
    complete(2'b00);
  endtask

  task automatic t_fifo_retry();
    cfg_fifo_order = 1'b1; cfg_one_shot = 1'b0;
    request(2'd2, 11'h700);
    wait_start(2'd2, "R5 blocker");
    request(2'd1, 11'h600);
    request(2'd0, 11'h010);
    complete(2'b00);
    wait_start(2'd1, "R5 oldest first");
    complete(2'b01);
    check(mb_pending[1] && mb_done == 0, "R6 error keeps pending",
          {mb_pending, mb_done}, 6'b011000);
    wait_start(2'd1, "R6 retry keeps place");
    complete(2'b10);
    check(mb_pending[1] && mb_done == 0, "R6 arb lost keeps pending",
          {mb_pending, mb_done}, 6'b011000);
    wait_start(2'd1, "R6 second retry");
    complete(2'b00);
    check(mb_ok[1] && mb_done == 3'b010, "R7 ok after retry", {mb_ok, mb_done}, 6'b010010);
    wait_start(2'd0, "R5 last");
    complete(2'b00);
    @(negedge clk);
  endtask

  task automatic t_backpressure();
    cfg_fifo_order = 1'b0;
    request(2'd0, 11'h123);
    wait_start(2'd0, "R2 start");
    @(negedge clk);
    req_valid = 1'b1; req_mb = 2'd0; req_id = 11'h7FE;
    @(negedge clk);
    check(!req_ready, "R2 ready low on pending", req_ready, 0);
    repeat (3) @(negedge clk);
    check(tx_id == 11'h123, "R2 held request no effect", tx_id, 11'h123);
    req_valid = 1'b0;
    complete(2'b00);
    check(req_ready, "R2 ready after release", req_ready, 1);
    @(negedge clk);
  endtask

  task automatic t_one_shot();
    cfg_one_shot = 1'b1;
    request(2'd1, 11'h222);
    wait_start(2'd1, "R8 start");
    complete(2'b10);
    check(mb_done == 3'b010 && !mb_pending[1], "R8 arb lost released",
          {mb_done, mb_pending}, 6'b010000);
    check(!mb_ok[1], "R8 status fail", mb_ok, 0);
    request(2'd2, 11'h333);
    wait_start(2'd2, "R8 start 2");
    complete(2'b01);
    check(mb_done == 3'b100 && !mb_ok[2], "R8 error released", {mb_done, mb_ok}, 6'b100000);
    @(negedge clk);
    check(!tx_busy && mb_pending == 0, "R8 idle after", mb_pending, 0);
    cfg_one_shot = 1'b0;
  endtask

  task automatic t_idle_done();
    logic [2:0] ok_before;
    ok_before = mb_ok;
    complete(2'b00);
    check(mb_done == 0 && !tx_busy && !tx_start, "R9 idle done ignored",
          {mb_done, tx_busy, tx_start}, 0);
    check(mb_ok == ok_before, "R9 status unchanged", mb_ok, ok_before);
  endtask

  task automatic t_rerequest();
    cfg_fifo_order = 1'b1;
    request(2'd0, 11'h010);
    wait_start(2'd0, "R10 blocker");
    request(2'd1, 11'h011);
    request(2'd2, 11'h012);
    complete(2'b00);
    wait_start(2'd1, "R10 order");
    request(2'd0, 11'h001);
    complete(2'b00);
    wait_start(2'd2, "R10 re-request ranks last");
    complete(2'b00);
    wait_start(2'd0, "R10 re-requested served");
    check(tx_id == 11'h001, "R10 new id", tx_id, 11'h001);
    complete(2'b00);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_id_priority();
    t_id_lowest();
    t_fifo_retry();
    t_backpressure();
    t_one_shot();
    t_idle_done();
    t_rerequest();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule